// File: doc/BRIEF.md
# Extremum-Count Impulse Noise Map Builder

This block builds the per-pixel noise map used to find isolated impulse noise in a grayscale image. An upstream window generator presents one 3×3 neighbourhood of pixels at a time, together with the linear address of its centre pixel. For each neighbourhood the block finds the brightest and the darkest pixel. It then updates a signed map word for each of the two: the brightest pixel's word is raised by one and the darkest pixel's word is lowered by one. The map is held in an external single-port synchronous RAM with one word per pixel, and each update is a read followed by a write on that one address port.

A pixel that is the brightest in all nine windows that cover it ends with +9 and is classed as salt. A pixel that is the darkest in all nine ends with −9 and is classed as pepper. Any other value means a healthy pixel. Because one signed counter serves both directions, a pixel that is both brightest and darkest in a flat window gains nothing and is never flagged.

A sweep has three phases. First a start pulse clears the whole map. Then the windows are processed, and the window marked as the last one ends this phase. Finally the block scans the map, counts the salt and pepper cells, and issues a one-cycle start pulse to the filtering stage that follows.

Top module: `impulse_map_detector`

## Requirements
- R1: While reset is held low, and after it is released until a sweep is started, winReady and filterStart are 0, saltCount and pepperCount are 0, and memWe is never asserted.
- R2: A sweepStart pulse while the block is idle writes the value 0 to every map cell, at addresses 0 to IMG_W*IMG_H−1. The block then raises winReady.
- R3: Window pixel k (k = 0..8) is winPix[8k+7:8k]. Its map address is winRef + (k/3 − 1)·IMG_W + (k%3 − 1), with winRef as the centre. The maximum and the minimum are the largest and smallest of the nine pixels. A tie goes to the lowest index k.
- R4: For each accepted window the map cell of the maximum pixel is incremented by one and the map cell of the minimum pixel is decremented by one. Each update reads the cell and then writes the new value through the single address port. Map words are 5-bit two's complement.
- R5: When the maximum and minimum resolve to the same index (all nine pixels equal), no map write is issued for that window.
- R6: Map updates saturate: incrementing +15 leaves +15, and decrementing −15 leaves −15. The pattern 10000 is never written.
- R7: A window is accepted on a clock edge where winValid and winReady are both 1. winReady returns to 1 five cycles after the accepting edge, or one cycle after it when R5 applies. No map write is issued while winReady is 1.
- R8: After the window accepted with winLast = 1 has been processed, the block reads every map cell. saltCount is set to the number of cells equal to 01001 (+9) and pepperCount to the number equal to 10111 (−9). filterStart is then 1 for exactly one cycle, and both counts hold their final values while it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sweepStart | input | 1 | Starts a sweep (map clear) when idle |
| winValid | input | 1 | A window is presented |
| winLast | input | 1 | The presented window is the final one of the image |
| winPix | input | 9*PIX_W | Nine window pixels, index k at bits 8k+7:8k |
| winRef | input | ADDR_W | Linear address of the window centre pixel |
| winReady | output | 1 | Block can accept a window |
| memAddr | output | ADDR_W | Map RAM address |
| memWe | output | 1 | Map RAM write enable |
| memWdata | output | CNT_W | Map RAM write data |
| memRdata | input | CNT_W | Map RAM read data, one cycle after the address |
| saltCount | output | ADDR_W+1 | Number of +9 cells after the sweep |
| pepperCount | output | ADDR_W+1 | Number of −9 cells after the sweep |
| filterStart | output | 1 | One-cycle pulse when the map and counts are complete |

## Verification
winReady comes back five edges after a window is accepted, or one edge after for a flat window. The bench counts the falling edges from acceptance to the return of winReady, and it reads the map cells only after that point, when both writes have landed. The clear phase ends one edge after the last of its IMG_W*IMG_H writes. The scan takes that many reads plus two edges before filterStart rises. The bench therefore polls for the pulse, checks the counts in the same cycle, and checks one falling edge later that the pulse has dropped. All inputs change on falling edges and all outputs and RAM contents are read there.

// File: rtl/impulse_map_pkg.sv
package impulse_map_pkg;

  typedef enum logic [1:0] {
    ADDR_SCAN = 2'd0,
    ADDR_MAX  = 2'd1,
    ADDR_MIN  = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     capture;
    addrSel_e addrSel;
    logic     memWe;
    logic     wrZero;
    logic     incr;
    logic     tallyClr;
    logic     tallyRd;
  } mapCtl_t;

endpackage

// File: rtl/impulse_map_extremum.sv
module impulse_map_extremum #(
  parameter int PIX_W = 8
) (
  input  logic [9*PIX_W-1:0] pix,
  output logic [3:0]         maxIdx,
  output logic [3:0]         minIdx
);

  // first level: three 3-input compare stages, one per window row
  for (genvar g = 0; g < 3; g++) begin : g_row
    logic [PIX_W-1:0] hiV, loV;
    logic [3:0]       hiI, loI;
    always_comb begin
      hiV = pix[(3*g)*PIX_W +: PIX_W];
      loV = pix[(3*g)*PIX_W +: PIX_W];
      hiI = 4'(3*g);
      loI = 4'(3*g);
      for (int j = 1; j < 3; j++) begin
        if (pix[(3*g+j)*PIX_W +: PIX_W] > hiV) begin
          hiV = pix[(3*g+j)*PIX_W +: PIX_W];
          hiI = 4'(3*g+j);
        end
        if (pix[(3*g+j)*PIX_W +: PIX_W] < loV) begin
          loV = pix[(3*g+j)*PIX_W +: PIX_W];
          loI = 4'(3*g+j);
        end
      end
    end
  end

  // second level: one 3-input stage over the row winners; strict compares keep the lower index
  logic [PIX_W-1:0] bestHi, bestLo;
  always_comb begin
    bestHi = g_row[0].hiV;
    maxIdx = g_row[0].hiI;
    if (g_row[1].hiV > bestHi) begin
      bestHi = g_row[1].hiV;
      maxIdx = g_row[1].hiI;
    end
    if (g_row[2].hiV > bestHi) begin
      bestHi = g_row[2].hiV;
      maxIdx = g_row[2].hiI;
    end
    bestLo = g_row[0].loV;
    minIdx = g_row[0].loI;
    if (g_row[1].loV < bestLo) begin
      bestLo = g_row[1].loV;
      minIdx = g_row[1].loI;
    end
    if (g_row[2].loV < bestLo) begin
      bestLo = g_row[2].loV;
      minIdx = g_row[2].loI;
    end
  end

endmodule

// File: rtl/impulse_map_datapath.sv
module impulse_map_datapath
  import impulse_map_pkg::*;
#(
  parameter int IMG_W  = 512,
  parameter int PIX_W  = 8,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 18,
  parameter int TOT_W  = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapCtl_t            ctl,
  input  logic [9*PIX_W-1:0] winPix,
  input  logic [ADDR_W-1:0]  winRef,
  input  logic [ADDR_W-1:0]  scanAddr,
  input  logic [CNT_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [CNT_W-1:0]   memWdata,
  output logic               sameCell,
  output logic [TOT_W-1:0]   saltCount,
  output logic [TOT_W-1:0]   pepperCount
);

  localparam int HITS = 9;
  localparam logic signed [CNT_W-1:0] CNT_HI      = CNT_W'((2**(CNT_W-1)) - 1);
  localparam logic signed [CNT_W-1:0] CNT_LO      = -CNT_HI;
  localparam logic signed [CNT_W-1:0] SALT_CODE   = CNT_W'(HITS);
  localparam logic signed [CNT_W-1:0] PEPPER_CODE = -SALT_CODE;

  logic [9*PIX_W-1:0] pixQ;
  logic [ADDR_W-1:0]  refQ;
  logic [3:0]         maxIdx, minIdx;
  logic               rdPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixQ <= '0;
      refQ <= '0;
    end else if (ctl.capture) begin
      pixQ <= winPix;
      refQ <= winRef;
    end
  end

  impulse_map_extremum #(.PIX_W(PIX_W)) u_ext (
    .pix    (pixQ),
    .maxIdx (maxIdx),
    .minIdx (minIdx)
  );

  assign sameCell = (maxIdx == minIdx);

  function automatic logic [ADDR_W-1:0] cellAddr(input logic [ADDR_W-1:0] ctr,
                                                 input logic [3:0] idx);
    logic [ADDR_W-1:0] a;
    a = ctr;
    case (int'(idx) / 3)
      0:       a = a - ADDR_W'(IMG_W);
      2:       a = a + ADDR_W'(IMG_W);
      default: a = a;
    endcase
    case (int'(idx) % 3)
      0:       a = a - ADDR_W'(1);
      2:       a = a + ADDR_W'(1);
      default: a = a;
    endcase
    return a;
  endfunction

  always_comb begin
    case (ctl.addrSel)
      ADDR_MAX: memAddr = cellAddr(refQ, maxIdx);
      ADDR_MIN: memAddr = cellAddr(refQ, minIdx);
      default:  memAddr = scanAddr;
    endcase
  end

  logic signed [CNT_W-1:0] oldVal, newVal;
  always_comb begin
    oldVal = signed'(memRdata);
    if (ctl.incr) newVal = (oldVal >= CNT_HI) ? CNT_HI : oldVal + CNT_W'(1);
    else          newVal = (oldVal <= CNT_LO) ? CNT_LO : oldVal - CNT_W'(1);
    memWdata = ctl.wrZero ? '0 : newVal;
  end

  // tally: the read issued in one cycle is classified in the next
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend      <= 1'b0;
      saltCount   <= '0;
      pepperCount <= '0;
    end else begin
      rdPend <= ctl.tallyRd;
      if (ctl.tallyClr) begin
        saltCount   <= '0;
        pepperCount <= '0;
      end else if (rdPend) begin
        if (memRdata == SALT_CODE)   saltCount   <= saltCount + 1'b1;
        if (memRdata == PEPPER_CODE) pepperCount <= pepperCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/impulse_map_control.sv
module impulse_map_control
  import impulse_map_pkg::*;
#(
  parameter int CELLS  = 262144,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepStart,
  input  logic              winValid,
  input  logic              winLast,
  input  logic              sameCell,
  output mapCtl_t           ctl,
  output logic [ADDR_W-1:0] scanAddr,
  output logic              winReady,
  output logic              filterStart
);

  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(CELLS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLEAR, S_RUN, S_FIND, S_RD_MAX, S_WR_MAX,
    S_RD_MIN, S_WR_MIN, S_TALLY, S_TWAIT, S_DONE
  } mapState_e;

  mapState_e         state;
  logic [ADDR_W-1:0] scanCnt;
  logic              lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      scanCnt <= '0;
      lastQ   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (sweepStart) begin
          state   <= S_CLEAR;
          scanCnt <= '0;
        end
        S_CLEAR: begin
          if (scanCnt == LAST_CELL) state <= S_RUN;
          else scanCnt <= scanCnt + 1'b1;
        end
        S_RUN: if (winValid) begin
          lastQ <= winLast;
          state <= S_FIND;
        end
        S_FIND: begin
          if (sameCell) begin
            state   <= lastQ ? S_TALLY : S_RUN;
            scanCnt <= '0;
          end else begin
            state <= S_RD_MAX;
          end
        end
        S_RD_MAX: state <= S_WR_MAX;
        S_WR_MAX: state <= S_RD_MIN;
        S_RD_MIN: state <= S_WR_MIN;
        S_WR_MIN: begin
          state   <= lastQ ? S_TALLY : S_RUN;
          scanCnt <= '0;
        end
        S_TALLY: begin
          if (scanCnt == LAST_CELL) state <= S_TWAIT;
          else scanCnt <= scanCnt + 1'b1;
        end
        S_TWAIT: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = ADDR_SCAN;
    case (state)
      S_IDLE:   ctl.tallyClr = sweepStart;
      S_CLEAR: begin
        ctl.memWe  = 1'b1;
        ctl.wrZero = 1'b1;
      end
      S_RUN:    ctl.capture = winValid;
      S_RD_MAX: ctl.addrSel = ADDR_MAX;
      S_WR_MAX: begin
        ctl.addrSel = ADDR_MAX;
        ctl.memWe   = 1'b1;
        ctl.incr    = 1'b1;
      end
      S_RD_MIN: ctl.addrSel = ADDR_MIN;
      S_WR_MIN: begin
        ctl.addrSel = ADDR_MIN;
        ctl.memWe   = 1'b1;
      end
      S_TALLY:  ctl.tallyRd = 1'b1;
      default:  ctl = ctl;
    endcase
  end

  assign scanAddr    = scanCnt;
  assign winReady    = (state == S_RUN);
  assign filterStart = (state == S_DONE);

endmodule

// File: rtl/impulse_map_detector.sv
module impulse_map_detector
  import impulse_map_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int PIX_W = 8,
  parameter int CNT_W = 5
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               sweepStart,
  input  logic                               winValid,
  input  logic                               winLast,
  input  logic [9*PIX_W-1:0]                 winPix,
  input  logic [$clog2(IMG_W*IMG_H)-1:0]     winRef,
  output logic                               winReady,
  output logic [$clog2(IMG_W*IMG_H)-1:0]     memAddr,
  output logic                               memWe,
  output logic [CNT_W-1:0]                   memWdata,
  input  logic [CNT_W-1:0]                   memRdata,
  output logic [$clog2(IMG_W*IMG_H+1)-1:0]   saltCount,
  output logic [$clog2(IMG_W*IMG_H+1)-1:0]   pepperCount,
  output logic                               filterStart
);

  localparam int CELLS  = IMG_W * IMG_H;
  localparam int ADDR_W = $clog2(CELLS);
  localparam int TOT_W  = $clog2(CELLS + 1);

  mapCtl_t           ctl;
  logic [ADDR_W-1:0] scanAddr;
  logic              sameCell;

  impulse_map_control #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sweepStart  (sweepStart),
    .winValid    (winValid),
    .winLast     (winLast),
    .sameCell    (sameCell),
    .ctl         (ctl),
    .scanAddr    (scanAddr),
    .winReady    (winReady),
    .filterStart (filterStart)
  );

  impulse_map_datapath #(
    .IMG_W(IMG_W), .PIX_W(PIX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TOT_W(TOT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .winPix      (winPix),
    .winRef      (winRef),
    .scanAddr    (scanAddr),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .sameCell    (sameCell),
    .saltCount   (saltCount),
    .pepperCount (pepperCount)
  );

  assign memWe = ctl.memWe;

endmodule

// File: rtl/impulse_map_detector_chk.sv
module impulse_map_detector_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             winValid,
  input logic             winReady,
  input logic             memWe,
  input logic [CNT_W-1:0] memWdata,
  input logic             filterStart
);

  p_ready_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    winReady |-> !memWe);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winReady) |=> !winReady);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWdata != {1'b1, {(CNT_W-1){1'b0}}}));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    filterStart |=> !filterStart);

  p_start_not_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    filterStart |-> !winReady);

endmodule

bind impulse_map_detector impulse_map_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .winValid    (winValid),
  .winReady    (winReady),
  .memWe       (memWe),
  .memWdata    (memWdata),
  .filterStart (filterStart)
);

// File: tb/impulse_map_detector_tb.sv
`timescale 1ns/1ps
module impulse_map_detector_tb;

  localparam int W      = 8;
  localparam int H      = 6;
  localparam int CELLS  = W * H;
  localparam int ADDR_W = $clog2(CELLS);
  localparam int TOT_W  = $clog2(CELLS + 1);

  function automatic logic [71:0] pk9(int a0, int a1, int a2, int a3, int a4,
                                      int a5, int a6, int a7, int a8);
    return {8'(a8), 8'(a7), 8'(a6), 8'(a5), 8'(a4), 8'(a3), 8'(a2), 8'(a1), 8'(a0)};
  endfunction

  typedef struct packed {
    logic [ADDR_W-1:0] ctr;
    logic [71:0]       pix;
    logic [3:0]        mx;
    logic [3:0]        mn;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{ctr: 6'd9,  pix: pk9(10,20,30,40,50,60,70,80,90),          mx: 4'd8, mn: 4'd0},
    '{ctr: 6'd10, pix: pk9(90,80,70,60,50,40,30,20,10),          mx: 4'd0, mn: 4'd8},
    '{ctr: 6'd11, pix: pk9(5,200,200,5,100,100,100,100,100),     mx: 4'd1, mn: 4'd0},
    '{ctr: 6'd12, pix: pk9(50,50,50,50,50,50,50,50,50),          mx: 4'd0, mn: 4'd0},
    '{ctr: 6'd13, pix: pk9(7,7,9,3,9,3,8,8,8),                   mx: 4'd2, mn: 4'd3},
    '{ctr: 6'd14, pix: pk9(1,2,3,4,250,6,7,8,0),                 mx: 4'd4, mn: 4'd8}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sweepStart = 1'b0;
  logic              winValid = 1'b0;
  logic              winLast = 1'b0;
  logic [71:0]       winPix = '0;
  logic [ADDR_W-1:0] winRef = '0;
  logic              winReady;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe;
  logic [4:0]        memWdata;
  logic [4:0]        memRdata;
  logic [TOT_W-1:0]  saltCount, pepperCount;
  logic              filterStart;

  always #2.5 clk = ~clk;

  impulse_map_detector #(.IMG_W(W), .IMG_H(H), .PIX_W(8), .CNT_W(5)) u_dut (
    .clk(clk), .rstN(rstN), .sweepStart(sweepStart), .winValid(winValid),
    .winLast(winLast), .winPix(winPix), .winRef(winRef), .winReady(winReady),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .saltCount(saltCount), .pepperCount(pepperCount), .filterStart(filterStart)
  );

  // map memory model: synchronous single-port RAM, prefilled with 7 during reset
  logic [4:0] ram [CELLS];
  int         weSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) ram[i] <= 5'd7;
      weSeen <= 0;
    end else begin
      if (memWe) begin
        ram[memAddr] <= memWdata;
        weSeen       <= weSeen + 1;
      end
      memRdata <= ram[memAddr];
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int mdl [CELLS];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cellOf(input int c, input int k);
    return c + (k / 3 - 1) * W + (k % 3 - 1);
  endfunction

  function automatic int ramVal(input int a);
    return int'($signed(ram[a]));
  endfunction

  task automatic applyModel(input int c, input int mx, input int mn);
    int a, b;
    if (mx != mn) begin
      a = cellOf(c, mx);
      b = cellOf(c, mn);
      mdl[a] = (mdl[a] >= 15) ? 15 : mdl[a] + 1;
      mdl[b] = (mdl[b] <= -15) ? -15 : mdl[b] - 1;
    end
  endtask

  task automatic findExt(input logic [71:0] p, output int mx, output int mn);
    mx = 0;
    mn = 0;
    for (int k = 1; k < 9; k++) begin
      if (p[8*k +: 8] > p[8*mx +: 8]) mx = k;
      if (p[8*k +: 8] < p[8*mn +: 8]) mn = k;
    end
  endtask

  task automatic sendWin(input int c, input logic [71:0] p, input bit last, output int lat);
    while (!winReady) @(negedge clk);
    winValid = 1'b1;
    winRef   = ADDR_W'(c);
    winPix   = p;
    winLast  = last;
    @(negedge clk);
    winValid = 1'b0;
    winLast  = 1'b0;
    lat = 0;
    if (!last) begin
      while (!winReady) begin
        @(negedge clk);
        lat++;
      end
    end
  endtask

  task automatic startSweep();
    sweepStart = 1'b1;
    @(negedge clk);
    sweepStart = 1'b0;
    while (!winReady) @(negedge clk);
    for (int i = 0; i < CELLS; i++) mdl[i] = 0;
  endtask

  task automatic finishSweep(input string tag);
    int s, p;
    s = 0;
    p = 0;
    while (!filterStart) @(negedge clk);
    for (int i = 0; i < CELLS; i++) begin
      if (mdl[i] == 9) s++;
      if (mdl[i] == -9) p++;
    end
    chk({"R8 saltCount ", tag}, int'(saltCount), s);
    chk({"R8 pepperCount ", tag}, int'(pepperCount), p);
    @(negedge clk);
    chk({"R8 filterStart one cycle ", tag}, int'(filterStart), 0);
  endtask

  function automatic int imgPix(input int r, input int c);
    if (r == 2 && c == 2) return 255;
    if (r == 3 && c == 5) return 0;
    return 100 + ((r * 5 + c * 3) % 37);
  endfunction

  initial begin
    int lat, we0, mx, mn, bad, zeros;
    logic [71:0] p;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 winReady in reset", int'(winReady), 0);
    chk("R1 filterStart in reset", int'(filterStart), 0);
    chk("R1 counts in reset", int'(saltCount) + int'(pepperCount), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 winReady idle", int'(winReady), 0);
    chk("R1 no write before sweep", weSeen, 0);
    chk("R1 filterStart idle", int'(filterStart), 0);

    // R2: clear phase
    startSweep();
    zeros = 0;
    for (int i = 0; i < CELLS; i++) if (ram[i] == 5'd0) zeros++;
    chk("R2 cells cleared", zeros, CELLS);
    chk("R2 clear write count", weSeen, CELLS);

    // table of windows: R3 selection and addressing, R4 update, R5 skip, R7 latency
    for (int v = 0; v < 6; v++) begin
      we0 = weSeen;
      sendWin(int'(VEC[v].ctr), VEC[v].pix, 1'b0, lat);
      applyModel(int'(VEC[v].ctr), int'(VEC[v].mx), int'(VEC[v].mn));
      if (VEC[v].mx == VEC[v].mn) begin
        chk($sformatf("R7 ready latency flat vec%0d", v), lat, 1);
        chk($sformatf("R5 no writes vec%0d", v), weSeen - we0, 0);
        chk($sformatf("R5 cell unchanged vec%0d", v),
            ramVal(cellOf(int'(VEC[v].ctr), 0)), mdl[cellOf(int'(VEC[v].ctr), 0)]);
      end else begin
        chk($sformatf("R7 ready latency vec%0d", v), lat, 5);
        chk($sformatf("R4 two writes vec%0d", v), weSeen - we0, 2);
        chk($sformatf("R3 R4 max cell vec%0d", v),
            ramVal(cellOf(int'(VEC[v].ctr), int'(VEC[v].mx))),
            mdl[cellOf(int'(VEC[v].ctr), int'(VEC[v].mx))]);
        chk($sformatf("R3 R4 min cell vec%0d", v),
            ramVal(cellOf(int'(VEC[v].ctr), int'(VEC[v].mn))),
            mdl[cellOf(int'(VEC[v].ctr), int'(VEC[v].mn))]);
      end
    end
    chk("R4 vec0 max cell 18 is +1", ramVal(18), 1);
    chk("R4 vec1 min cell 19 is -1", ramVal(19), -1);

    // R6: saturation, 17 hits on cells 20 (max) and 11 (min)
    p = pk9(0, 50, 50, 50, 200, 50, 50, 50, 50);
    for (int n = 0; n < 17; n++) begin
      sendWin(20, p, (n == 16), lat);
      applyModel(20, 4, 0);
    end
    finishSweep("phase A");
    chk("R6 saturate high", ramVal(20), 15);
    chk("R6 saturate low", ramVal(11), -15);

    // full image sweep with one salt (cell 18) and one pepper (cell 29)
    startSweep();
    for (int r = 1; r < H - 1; r++) begin
      for (int c = 1; c < W - 1; c++) begin
        p = pk9(imgPix(r-1,c-1), imgPix(r-1,c), imgPix(r-1,c+1),
                imgPix(r,c-1),   imgPix(r,c),   imgPix(r,c+1),
                imgPix(r+1,c-1), imgPix(r+1,c), imgPix(r+1,c+1));
        findExt(p, mx, mn);
        applyModel(r * W + c, mx, mn);
        sendWin(r * W + c, p, (r == H - 2 && c == W - 2), lat);
      end
    end
    finishSweep("phase B");
    chk("R8 salt cell value", ramVal(18), 9);
    chk("R8 pepper cell value", ramVal(29), -9);
    bad = 0;
    for (int i = 0; i < CELLS; i++) if (ramVal(i) != mdl[i]) bad++;
    chk("R3 R4 whole map matches", bad, 0);
    chk("R8 at least one salt", int'(saltCount >= 1), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=filterStart");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule